// File: doc/BRIEF.md
# Cartridge Bank-Mapping Register File

This block sits on the cartridge side of a game console and holds the bank-select state of a memory mapper. The CPU writes to addresses from 0x8000 up to 0xFFFF, and the block decodes those writes into bank registers. At the same time it translates two live address streams into physical ROM addresses. The CPU read address is turned into a program-ROM address. The picture-bus address is turned into a character-ROM address. Both translations are combinational from the held register state, so a ROM wrapped around this block sees the mapped address in the same cycle as the request.

The CPU space from 0x8000 is split into four 8 KB windows. The first two windows take a bank number written by the CPU. The upper two windows are tied to the last two banks of program ROM, and those bank numbers are computed from the bank-count parameter. The 8 KB character space is split into eight 1 KB windows. Each window's 8-bit bank number is built from two separate 4-bit writes.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the four program windows (CPU addresses 0x8000, 0xA000, 0xC000, 0xE000) map to banks 0, 1, PRG_BANKS-2 and PRG_BANKS-1. Character window i maps to bank i.
- R2: A strobed write whose address bits 15:12 equal 0x8 loads the whole data byte as the bank of the 0x8000 window. The low 12 address bits do not matter.
- R3: A strobed write whose address bits 15:12 equal 0xA loads the whole data byte as the bank of the 0xA000 window.
- R4: The 0xC000 window always maps to bank PRG_BANKS-2 and the 0xE000 window always maps to bank PRG_BANKS-1, whatever is written.
- R5: A character write at in-page offset 0x0 or 0x8 (address bits 3:2 = 00 or 10) replaces the low nibble of the selected bank with data bits 3:0. The high nibble is kept, and data bits 7:4 are ignored.
- R6: A character write at in-page offset 0x4 or 0xC (address bits 3:2 = 01 or 11) replaces the high nibble of the selected bank with data bits 3:0. The low nibble is kept.
- R7: Character writes are decoded only on address bits 15:12 and 3. Page 0xB selects windows 0 (bit 3 = 0) and 1 (bit 3 = 1). Page 0xC selects windows 2 and 3, page 0xD selects windows 4 and 5, and page 0xE selects windows 6 and 7. Address bits 11:4 and 1:0 are ignored.
- R8: The character-ROM address is the bank of the window picked by picture address bits 12:10, followed by picture address bits 9:0.
- R9: The program-ROM address is the bank of the window picked by CPU address bits 14:13, followed by CPU address bits 12:0.
- R10: Writes to pages 0x0–0x7, 0x9 and 0xF, and any write with the strobe low, change no mapping.
- R11: A write takes effect at the clock edge that samples it. Translations before that edge use the old bank, and translations after it use the new bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr_en | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_wr_addr | input | 16 | CPU write address |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_rd_addr | input | 16 | CPU read address to translate |
| ppu_addr | input | 14 | Picture-bus address to translate |
| prg_rom_addr | output | 21 | Physical program-ROM address |
| chr_rom_addr | output | 18 | Physical character-ROM address |

## Verification
Some properties are checked on every cycle. The offset bits pass straight through both translations. The two upper program windows stay pinned to their computed banks. A cycle with no write leaves both translations unchanged while their inputs hold. A write to page 0x8 shows up in the first window one cycle later.

Other behaviour is shown only by the bench's scenarios. These are the nibble merging, the page-and-offset order that maps registers to windows, the ignored address bits, the reset pattern of the character banks, and the before-edge and after-edge view of a write.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
  localparam int BANK_W    = 8;
  localparam int NIB_W     = 4;
  localparam int DATA_W    = 8;
  localparam int CPU_AW    = 16;
  localparam int PPU_AW    = 14;
  localparam int PRG_OFS_W = 13;
  localparam int CHR_OFS_W = 10;
  localparam int PRG_WIN   = 4;
  localparam int PRG_SW    = 2;
  localparam int CHR_WIN   = 8;
  localparam int CHR_PAGES = CHR_WIN / 2;
  localparam int PRG_SEL_W = $clog2(PRG_WIN);
  localparam int CHR_SEL_W = $clog2(CHR_WIN);
  localparam int PRG_OUT_W = BANK_W + PRG_OFS_W;
  localparam int CHR_OUT_W = BANK_W + CHR_OFS_W;

  localparam logic [3:0] PG_PRG0      = 4'h8;
  localparam logic [3:0] PG_PRG1      = 4'hA;
  localparam logic [3:0] PG_CHR_FIRST = 4'hB;

  typedef logic [BANK_W-1:0] bank_t;

  typedef struct packed {
    logic [PRG_SW-1:0]  prg_we;
    logic [CHR_WIN-1:0] chr_we;
    logic               chr_hi;
  } wr_cmd_t;
endpackage

// File: rtl/cmap_wr_decode.sv
module cmap_wr_decode
  import cmap_pkg::*;
(
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] wr_addr,
  output wr_cmd_t           cmd
);
  logic [3:0] page;
  logic [3:0] chr_rel;
  logic       unused_bits;

  assign page    = wr_addr[15:12];
  assign chr_rel = page - PG_CHR_FIRST;

  always_comb begin
    cmd        = '0;
    cmd.chr_hi = wr_addr[2];
    if (wr_en) begin
      cmd.prg_we[0] = (page == PG_PRG0);
      cmd.prg_we[1] = (page == PG_PRG1);
      for (int p = 0; p < CHR_PAGES; p++) begin
        if (chr_rel == 4'(p)) begin
          cmd.chr_we[2*p]   = !wr_addr[3];
          cmd.chr_we[2*p+1] =  wr_addr[3];
        end
      end
    end
  end

  assign unused_bits = ^{wr_addr[11:4], wr_addr[1:0]};
endmodule

// File: rtl/cmap_prg_map.sv
module cmap_prg_map
  import cmap_pkg::*;
#(
  parameter int PRG_BANKS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PRG_SW-1:0]    prg_we,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [CPU_AW-1:0]    rd_addr,
  output logic [PRG_OUT_W-1:0] prg_addr
);
  localparam bank_t FIX_LO = bank_t'(PRG_BANKS - 2);
  localparam bank_t FIX_HI = bank_t'(PRG_BANKS - 1);

  bank_t                sw_q   [PRG_SW];
  bank_t                sw_d   [PRG_SW];
  bank_t                win_bank [PRG_WIN];
  logic [PRG_SEL_W-1:0] sel;
  logic                 unused_bits;

  for (genvar g = 0; g < PRG_SW; g++) begin : g_sw
    always_comb sw_d[g] = bank_t'(wr_data);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sw_q[g] <= bank_t'(g);
      else if (prg_we[g]) sw_q[g] <= sw_d[g];
    end
  end

  always_comb begin
    for (int w = 0; w < PRG_SW; w++) win_bank[w] = sw_q[w];
    win_bank[PRG_WIN-2] = FIX_LO;
    win_bank[PRG_WIN-1] = FIX_HI;
  end

  assign sel         = rd_addr[PRG_OFS_W +: PRG_SEL_W];
  assign prg_addr    = {win_bank[sel], rd_addr[PRG_OFS_W-1:0]};
  assign unused_bits = rd_addr[CPU_AW-1];
endmodule

// File: rtl/cmap_chr_map.sv
module cmap_chr_map
  import cmap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CHR_WIN-1:0]   chr_we,
  input  logic                 chr_hi,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [PPU_AW-1:0]    ppu_addr,
  output logic [CHR_OUT_W-1:0] chr_addr
);
  bank_t                reg_q [CHR_WIN];
  bank_t                reg_d [CHR_WIN];
  logic [NIB_W-1:0]     nib;
  logic [CHR_SEL_W-1:0] sel;
  logic                 unused_bits;

  assign nib = wr_data[NIB_W-1:0];

  for (genvar g = 0; g < CHR_WIN; g++) begin : g_reg
    always_comb begin
      if (chr_hi) reg_d[g] = {nib, reg_q[g][NIB_W-1:0]};
      else        reg_d[g] = {reg_q[g][BANK_W-1:NIB_W], nib};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reg_q[g] <= bank_t'(g);
      else if (chr_we[g]) reg_q[g] <= reg_d[g];
    end
  end

  assign sel         = ppu_addr[CHR_OFS_W +: CHR_SEL_W];
  assign chr_addr    = {reg_q[sel], ppu_addr[CHR_OFS_W-1:0]};
  assign unused_bits = ^{wr_data[DATA_W-1:NIB_W], ppu_addr[PPU_AW-1]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cmap_pkg::*;
#(
  parameter int PRG_BANKS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr_en,
  input  logic [15:0] cpu_wr_addr,
  input  logic [7:0]  cpu_wr_data,
  input  logic [15:0] cpu_rd_addr,
  input  logic [13:0] ppu_addr,
  output logic [20:0] prg_rom_addr,
  output logic [17:0] chr_rom_addr
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  wr_cmd_t    cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cmap_wr_decode u_dec (
    .wr_en   (cpu_wr_en),
    .wr_addr (cpu_wr_addr),
    .cmd     (cmd)
  );

  cmap_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .prg_we   (cmd.prg_we),
    .wr_data  (cpu_wr_data),
    .rd_addr  (cpu_rd_addr),
    .prg_addr (prg_rom_addr)
  );

  cmap_chr_map u_chr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .chr_we   (cmd.chr_we),
    .chr_hi   (cmd.chr_hi),
    .wr_data  (cpu_wr_data),
    .ppu_addr (ppu_addr),
    .chr_addr (chr_rom_addr)
  );
endmodule

// File: rtl/cmap_checker.sv
module cmap_checker #(
  parameter int PRG_BANKS = 32
) (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        cpu_wr_en,
  input logic [15:0] cpu_wr_addr,
  input logic [7:0]  cpu_wr_data,
  input logic [15:0] cpu_rd_addr,
  input logic [13:0] ppu_addr,
  input logic [20:0] prg_rom_addr,
  input logic [17:0] chr_rom_addr
);
  localparam logic [7:0] LAST = 8'(PRG_BANKS - 1);
  localparam logic [7:0] PREV = 8'(PRG_BANKS - 2);

  logic unused_bits;
  assign unused_bits = ^cpu_wr_addr[11:0];

  assert_fixed_c000_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_rd_addr[15:13] == 3'b110) |-> (prg_rom_addr[20:13] == PREV));

  assert_fixed_e000_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_rd_addr[15:13] == 3'b111) |-> (prg_rom_addr[20:13] == LAST));

  assert_prg_offset_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    prg_rom_addr[12:0] == cpu_rd_addr[12:0]);

  assert_chr_offset_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chr_rom_addr[9:0] == ppu_addr[9:0]);

  assert_prg_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!$past(cpu_wr_en) && $stable(cpu_rd_addr)) |-> $stable(prg_rom_addr));

  assert_chr_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!$past(cpu_wr_en) && $stable(ppu_addr)) |-> $stable(chr_rom_addr));

  assert_page8_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_wr_en && cpu_wr_addr[15:12] == 4'h8) |=>
      ((cpu_rd_addr[15:13] == 3'b100) -> (prg_rom_addr[20:13] == $past(cpu_wr_data))));
endmodule

bind cart_bank_mapper cmap_checker #(.PRG_BANKS(PRG_BANKS)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cpu_wr_en    (cpu_wr_en),
  .cpu_wr_addr  (cpu_wr_addr),
  .cpu_wr_data  (cpu_wr_data),
  .cpu_rd_addr  (cpu_rd_addr),
  .ppu_addr     (ppu_addr),
  .prg_rom_addr (prg_rom_addr),
  .chr_rom_addr (chr_rom_addr)
);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  localparam int NB = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr_en;
  logic [15:0] cpu_wr_addr;
  logic [7:0]  cpu_wr_data;
  logic [15:0] cpu_rd_addr;
  logic [13:0] ppu_addr;
  logic [20:0] prg_rom_addr;
  logic [17:0] chr_rom_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr),
    .cpu_wr_data(cpu_wr_data), .cpu_rd_addr(cpu_rd_addr), .ppu_addr(ppu_addr),
    .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr)
  );

  typedef struct packed {
    logic [15:0] wa;
    logic [7:0]  wd;
    logic        is_chr;
    logic [15:0] pa;
    logic [20:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{16'h8000, 8'h05, 1'b0, 16'h8123, {8'h05, 13'h0123}},           // R2
    '{16'h8FFF, 8'hA7, 1'b0, 16'h9FFF, {8'hA7, 13'h1FFF}},           // R2 low bits ignored
    '{16'hA010, 8'h3C, 1'b0, 16'hA000, {8'h3C, 13'h0000}},           // R3
    '{16'hC000, 8'h55, 1'b1, 16'h0800, 21'({8'h05, 10'h000})},       // R5 high nibble kept
    '{16'hC004, 8'hF9, 1'b1, 16'h0BFF, 21'({8'h95, 10'h3FF})},       // R6
    '{16'hB008, 8'h0E, 1'b1, 16'h0400, 21'({8'h0E, 10'h000})},       // R5 R7
    '{16'hB00C, 8'h02, 1'b1, 16'h07FF, 21'({8'h2E, 10'h3FF})},       // R6 R7
    '{16'hE00C, 8'h07, 1'b1, 16'h1C10, 21'({8'h77, 10'h010})},       // R6 R7 R8
    '{16'hD7F8, 8'h0A, 1'b1, 16'h1400, 21'({8'h0A, 10'h000})},       // R7 ignored bits
    '{16'hE000, 8'hFF, 1'b0, 16'hE000, {8'(NB-1), 13'h0000}},        // R4
    '{16'hC000, 8'h11, 1'b0, 16'hC456, {8'(NB-2), 13'h0456}},        // R4 R9
    '{16'h9000, 8'h66, 1'b0, 16'h8000, {8'hA7, 13'h0000}},           // R10 page 9
    '{16'hF004, 8'h33, 1'b1, 16'h0000, 21'({8'h00, 10'h000})},       // R10 page F
    '{16'h7000, 8'h44, 1'b0, 16'hA000, {8'h3C, 13'h0000}},           // R10 low page
    '{16'hB003, 8'h09, 1'b1, 16'h03FF, 21'({8'h09, 10'h3FF})}        // R7 bits 1:0 ignored
  };

  task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    for (int i = 0; i < 8; i++) begin
      ppu_addr = 14'(i * 1024);
      #1;
      check(tag, 21'(chr_rom_addr), 21'({8'(i), 10'h000}));
    end
    cpu_rd_addr = 16'h8000; #1; check(tag, prg_rom_addr, {8'd0, 13'h0});
    cpu_rd_addr = 16'hA000; #1; check(tag, prg_rom_addr, {8'd1, 13'h0});
    cpu_rd_addr = 16'hC000; #1; check(tag, prg_rom_addr, {8'(NB-2), 13'h0});
    cpu_rd_addr = 16'hE000; #1; check(tag, prg_rom_addr, {8'(NB-1), 13'h0});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_wr_en = 1'b0; cpu_wr_addr = '0; cpu_wr_data = '0;
    cpu_rd_addr = 16'h8000; ppu_addr = '0;
    do_reset();
    check_reset_state("R1 reset");

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v].wa, VEC[v].wd);
      if (VEC[v].is_chr) ppu_addr = VEC[v].pa[13:0];
      else               cpu_rd_addr = VEC[v].pa;
      #1;
      if (VEC[v].is_chr)
        check($sformatf("table %0d R5,R6,R7,R8,R10", v), 21'(chr_rom_addr), VEC[v].exp);
      else
        check($sformatf("table %0d R2,R3,R4,R9,R10", v), prg_rom_addr, VEC[v].exp);
    end

    // R10: strobe low leaves the mapping alone
    @(negedge clk);
    cpu_wr_addr = 16'h8000; cpu_wr_data = 8'h99;
    repeat (2) @(negedge clk);
    cpu_rd_addr = 16'h8000; #1;
    check("R10 strobe low", prg_rom_addr, {8'hA7, 13'h0});

    // R11: old bank before the edge, new bank after it
    cpu_rd_addr = 16'hA000;
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_addr = 16'hA000; cpu_wr_data = 8'h12;
    #1;
    check("R11 before edge", prg_rom_addr, {8'h3C, 13'h0});
    @(negedge clk);
    cpu_wr_en = 1'b0; #1;
    check("R11 after edge", prg_rom_addr, {8'h12, 13'h0});

    // R8: window select from bits 12:10 with bit 13 set
    ppu_addr = 14'h2BFF; #1;
    check("R8 window 2", 21'(chr_rom_addr), 21'({8'h91, 10'h3FF}));

    // R1: reset in mid-run restores the initial pattern
    do_reset();
    check_reset_state("R1 second reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule